// File: doc/BRIEF.md
# Serial Byte Target with Sticky Status

This block lets an external serial bus master exchange bytes with a host processor. The master drives the serial clock, the data line toward the block and an active-low select. The block drives the return data line. All three incoming lines are brought into the system clock domain through two-flop synchronizers and edge-detected there, so the serial clock must run well below the system clock (at least about four system cycles per serial half-period). Transfers use clock mode 0. The incoming line is sampled on the rising serial clock edge, the return line changes on the falling edge, and the most significant bit goes first. A transfer begins on the falling edge of select and ends after 8 bits.

The host sees two registers, chosen by a one-bit address. Address 0 is the control/status register. Address 1 is the data buffer: a write loads the byte to be sent, and a read returns the last byte kept from the bus. The host bus is a plain register port. It has no back-pressure: every write and every read completes in the cycle it is presented. Three sticky flags record a finished byte, a lost byte and a rejected buffer write. Their OR, gated by an enable input, forms the interrupt. Software may set any of the three flags itself to raise the interrupt.

Top module: `spis_top`

## Requirements
- R1: After reset, the control/status register reads 0x00, the data buffer reads 0x00 and irq is low.
- R2: Bit 7 of the control/status register (busy) reads 1 from the start of a transfer until its 8th bit is taken or it is aborted. Host writes to bit 7 have no effect.
- R3: While selected, the block samples mosi on each rising sclk edge and drives miso on each falling edge, most significant bit first. It sends the byte held in the transmit buffer. A completed byte is stored in the data buffer at address 1 when it is not lost (see R5).
- R4: Bit 6 (complete) is set at the end of every full 8-bit transfer and stays set until the host writes 0 to it. If the hardware sets it in the same cycle as a host write of 0, it stays 1.
- R5: Bit 5 (overrun) is set when a byte completes while the previous byte has not been read from address 1. The new byte is discarded and the buffer keeps the earlier byte.
- R6: A write to address 1 while busy is 1 sets bit 4 (write collision). It changes neither the byte being shifted out nor the transmit buffer, so the following transfer sends the old byte again.
- R7: A host write of 1 to bit 6, 5 or 4 sets that flag.
- R8: irq equals irq_en AND (bit 6 OR bit 5 OR bit 4).
- R9: Raising ss_n before the 8th bit aborts the byte. Busy clears, complete is not set and the data buffer is left unchanged.
- R10: The block takes part in transfers only when bit 0 (enable) is 1 and bit 1 (master select) is 0. Bits 3 and 2 are stored and read back but change nothing.
- R11: A read of address 1 clears the unread marker, so the next completed byte is stored without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low select from the master |
| miso | output | 1 | Serial data to the master (0 when not selected) |
| addr | input | 1 | Register select: 0 control/status, 1 data buffer |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (a read of address 1 marks the byte as read) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for the register at addr (combinational) |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Two actions can land in the same system cycle: the hardware setting the complete flag when the last bit is taken, and a host write that clears that flag. The bench forces this collision by issuing a control write of 0x01 in the exact cycle the 8th rising sclk edge leaves the synchronizer. That cycle is the third system edge after sclk is driven. The control register must then read 0x41, because the hardware set wins. A second overlap is a host write to the buffer during a transfer. The bench checks it through the collision flag and through the byte sent on the next transfer.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int CTRL_W = 8;
  localparam int B_BUSY = 7;
  localparam int B_CMP  = 6;
  localparam int B_OVR  = 5;
  localparam int B_WCOL = 4;
  localparam int B_MF   = 3;
  localparam int B_MFE  = 2;
  localparam int B_MST  = 1;
  localparam int B_EN   = 0;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_DATA = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign lvl = stage_q[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
module spis_edge #(
  parameter int N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else prev_q <= lvl;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_det
      assign rise[i] = lvl[i] & ~prev_q[i];
      assign fall[i] = ~lvl[i] & prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/spis_shift.sv
module spis_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          ss_fall,
  input  logic          ss_rise,
  input  logic          ss_lvl,
  input  logic          mosi_s,
  input  logic [DW-1:0] tx_buf,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          miso
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q;
  logic [DW-2:0] rx_q;
  logic [DW-1:0] tx_q;
  logic          busy_q;
  logic          take;

  assign take    = busy_q & sclk_rise;
  assign done    = take & (cnt_q == LAST) & active & ~ss_rise;
  assign rx_byte = {rx_q, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else if (!active || ss_rise) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ss_fall) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      tx_q   <= tx_buf;
    end else if (busy_q) begin
      if (sclk_rise) begin
        rx_q  <= rx_byte[DW-2:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) busy_q <= 1'b0;
      end else if (sclk_fall) begin
        tx_q <= {tx_q[DW-2:0], 1'b0};
      end
    end
  end

  assign busy = busy_q;
  assign miso = ~ss_lvl & tx_q[DW-1];
endmodule

// File: rtl/spis_regs.sv
module spis_regs
  import spis_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          irq_en,
  output logic          irq,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DW-1:0] tx_buf,
  output logic [DW-1:0] rx_buf,
  output logic          active
);
  logic cmp_q, ovr_q, wcol_q, mf_q, mfe_q, mst_q, en_q, unread_q;
  logic [DW-1:0] tx_q, rx_q;
  logic wr_ctrl, wr_data, rd_data, ovr_evt, wcol_evt, store;

  assign wr_ctrl  = wr_en & (addr == REG_CTRL);
  assign wr_data  = wr_en & (addr == REG_DATA);
  assign rd_data  = rd_en & (addr == REG_DATA);
  assign wcol_evt = wr_data & busy;
  assign ovr_evt  = done & unread_q & ~rd_data;
  assign store    = done & ~ovr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cmp_q, ovr_q, wcol_q, mf_q, mfe_q, mst_q, en_q} <= '0;
      unread_q <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        mf_q  <= wdata[B_MF];
        mfe_q <= wdata[B_MFE];
        mst_q <= wdata[B_MST];
        en_q  <= wdata[B_EN];
      end
      if (done) cmp_q <= 1'b1;
      else if (wr_ctrl) cmp_q <= wdata[B_CMP];
      if (ovr_evt) ovr_q <= 1'b1;
      else if (wr_ctrl) ovr_q <= wdata[B_OVR];
      if (wcol_evt) wcol_q <= 1'b1;
      else if (wr_ctrl) wcol_q <= wdata[B_WCOL];
      if (wr_data && !busy) tx_q <= wdata;
      if (store) begin
        rx_q     <= rx_byte;
        unread_q <= 1'b1;
      end else if (rd_data) begin
        unread_q <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrl = '0;
    ctrl[B_BUSY] = busy;
    ctrl[B_CMP]  = cmp_q;
    ctrl[B_OVR]  = ovr_q;
    ctrl[B_WCOL] = wcol_q;
    ctrl[B_MF]   = mf_q;
    ctrl[B_MFE]  = mfe_q;
    ctrl[B_MST]  = mst_q;
    ctrl[B_EN]   = en_q;
  end

  always_comb begin
    rdata = '0;
    if (addr == REG_DATA) rdata = rx_q;
    else rdata[CTRL_W-1:0] = ctrl;
  end

  assign irq    = irq_en & (cmp_q | ovr_q | wcol_q);
  assign active = en_q & ~mst_q;
  assign tx_buf = tx_q;
  assign rx_buf = rx_q;
endmodule

// File: rtl/spis_top.sv
module spis_top
  import spis_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          mosi,
  input  logic          ss_n,
  output logic          miso,
  input  logic          addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          irq_en,
  output logic          irq
);
  localparam int L_SCLK = 0;
  localparam int L_MOSI = 1;
  localparam int L_SS   = 2;

  logic [2:0] lvl;
  logic [1:0] rise, fall;
  logic busy, done, active;
  logic [DW-1:0] rx_byte, tx_buf, rx_buf;
  logic [CTRL_W-1:0] ctrl;

  spis_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ss_n, mosi, sclk}), .lvl(lvl)
  );

  spis_edge #(.N(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl({lvl[L_SS], lvl[L_SCLK]}),
    .rise(rise), .fall(fall)
  );

  spis_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(active),
    .sclk_rise(rise[0]), .sclk_fall(fall[0]),
    .ss_fall(fall[1]), .ss_rise(rise[1]), .ss_lvl(lvl[L_SS]),
    .mosi_s(lvl[L_MOSI]), .tx_buf(tx_buf),
    .busy(busy), .done(done), .rx_byte(rx_byte), .miso(miso)
  );

  spis_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_en(irq_en), .irq(irq),
    .busy(busy), .done(done), .rx_byte(rx_byte), .ctrl(ctrl),
    .tx_buf(tx_buf), .rx_buf(rx_buf), .active(active)
  );
endmodule

// File: rtl/spis_chk.sv
module spis_chk
  import spis_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr,
  input logic              wr_en,
  input logic [DW-1:0]     wdata,
  input logic              irq_en,
  input logic              irq,
  input logic              busy,
  input logic              active,
  input logic [CTRL_W-1:0] ctrl,
  input logic [DW-1:0]     tx_buf,
  input logic [DW-1:0]     rx_buf
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en & (addr == REG_CTRL);

  a_r4_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_CMP] && !(wr_ctrl && !wdata[B_CMP])) |=> ctrl[B_CMP]);

  a_r4_cmp_from_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[B_CMP] && !wr_ctrl) |=> (!ctrl[B_CMP] || $past(busy)));

  a_r5_ovr_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[B_OVR] && !wr_ctrl) |=> (!ctrl[B_OVR] || $stable(rx_buf)));

  a_r6_wcol_keeps_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_DATA && busy) |=> ($stable(tx_buf) && ctrl[B_WCOL]));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !busy);
endmodule

bind spis_top spis_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .irq_en(irq_en), .irq(irq), .busy(busy), .active(active), .ctrl(ctrl),
  .tx_buf(tx_buf), .rx_buf(rx_buf)
);

// File: tb/test_spis_top.sv
module test_spis_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic miso;
  logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_en = 1'b1;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got, rv;

  always #2.5 clk = ~clk;

  spis_top i_spis_top (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
    .miso(miso), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // Monitor side of the scoreboard: pop the expected byte and compare with a buffer read.
  task automatic pop_check(input string req);
    logic [7:0] e;
    host_rd(1'b1, rv);
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL %s actual=%h expected=<empty queue>", req, rv);
    end else begin
      e = exp_q.pop_front();
      chk(req, rv, e);
    end
  endtask

  task automatic spi_begin();
    @(negedge clk); ss_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic spi_end();
    @(negedge clk); ss_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // Drives n bits MSB first; when hit is set, a control write of 0x01 lands in the
  // same cycle the last rising edge is taken (third system edge after sclk rises).
  task automatic spi_bits(input logic [7:0] b, input int n, input bit hit, output logic [7:0] g);
    g = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mosi = b[7-i];
      repeat (3) @(negedge clk);
      g = {g[6:0], miso};
      @(negedge clk); sclk = 1'b1;
      if (hit && i == n-1) begin
        @(negedge clk);
        @(negedge clk); addr = 1'b0; wdata = 8'h01; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        repeat (5) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic spi_xfer(input logic [7:0] b, output logic [7:0] g);
    spi_begin();
    spi_bits(b, 8, 1'b0, g);
    spi_end();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    host_rd(1'b0, rv); chk("R1 ctrl", rv, 8'h00);
    host_rd(1'b1, rv); chk("R1 data", rv, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    host_wr(1'b0, 8'h01);
    host_wr(1'b0, 8'h81);
    host_rd(1'b0, rv); chk("R2 busy not writable", rv, 8'h01);

    // R3 basic exchange, R2 busy during transfer
    host_wr(1'b1, 8'hA5);
    spi_begin();
    host_rd(1'b0, rv); chk("R2 busy set", rv, 8'h81);
    spi_bits(8'h3C, 8, 1'b0, got);
    spi_end();
    chk("R3 miso byte", got, 8'hA5);
    exp_q.push_back(8'h3C);
    host_rd(1'b0, rv); chk("R4 complete set", rv, 8'h41);
    chk("R8 irq on complete", {7'b0, irq}, 8'h01);
    pop_check("R3 rx byte");
    host_wr(1'b0, 8'h01);
    host_rd(1'b0, rv); chk("R4 cleared", rv, 8'h01);
    chk("R8 irq low", {7'b0, irq}, 8'h00);

    // R5 overrun keeps older byte
    spi_xfer(8'h22, got); exp_q.push_back(8'h22);
    spi_xfer(8'h11, got);
    host_rd(1'b0, rv); chk("R5 overrun flag", rv, 8'h61);
    pop_check("R5 older byte kept");
    host_wr(1'b0, 8'h01);

    // R11 read clears unread marker
    spi_xfer(8'h5A, got); exp_q.push_back(8'h5A);
    host_rd(1'b0, rv); chk("R11 no overrun after read", rv, 8'h41);
    pop_check("R11 new byte stored");
    host_wr(1'b0, 8'h01);

    // R6 write collision
    host_wr(1'b1, 8'hC3);
    spi_begin();
    host_wr(1'b1, 8'h77);
    host_rd(1'b0, rv); chk("R6 wcol during busy", rv, 8'h91);
    spi_bits(8'h00, 8, 1'b0, got);
    spi_end();
    chk("R6 shifting byte unchanged", got, 8'hC3);
    exp_q.push_back(8'h00);
    host_rd(1'b0, rv); chk("R6 flags after", rv, 8'h51);
    pop_check("R6 rx byte");
    host_wr(1'b0, 8'h01);
    spi_xfer(8'h0F, got); exp_q.push_back(8'h0F);
    chk("R6 tx buffer unchanged", got, 8'hC3);
    pop_check("R6 rx second");
    host_wr(1'b0, 8'h01);

    // R9 abort mid-byte
    spi_begin();
    spi_bits(8'hFF, 4, 1'b0, got);
    spi_end();
    host_rd(1'b0, rv); chk("R9 no complete on abort", rv, 8'h01);
    host_rd(1'b1, rv); chk("R9 buffer unchanged", rv, 8'h0F);
    spi_xfer(8'h96, got); exp_q.push_back(8'h96);
    chk("R9 next transfer ok", got, 8'hC3);
    pop_check("R9 rx after abort");
    host_wr(1'b0, 8'h01);

    // R7 software set, R8 gating
    host_wr(1'b0, 8'h21);
    host_rd(1'b0, rv); chk("R7 sw set overrun", rv, 8'h21);
    chk("R7 irq from sw set", {7'b0, irq}, 8'h01);
    @(negedge clk); irq_en = 1'b0; #1;
    chk("R8 irq masked", {7'b0, irq}, 8'h00);
    @(negedge clk); irq_en = 1'b1;
    host_wr(1'b0, 8'h11);
    host_rd(1'b0, rv); chk("R7 sw set wcol", rv, 8'h11);
    chk("R8 irq from wcol", {7'b0, irq}, 8'h01);
    host_wr(1'b0, 8'h41);
    host_rd(1'b0, rv); chk("R7 sw set complete", rv, 8'h41);
    host_wr(1'b0, 8'h01);

    // R10 mode-fault bits inert, disable and master select ignore the bus
    host_wr(1'b0, 8'h0D);
    spi_xfer(8'h3F, got); exp_q.push_back(8'h3F);
    host_rd(1'b0, rv); chk("R10 fault bits inert", rv, 8'h4D);
    pop_check("R10 rx with fault bits");
    host_wr(1'b0, 8'h00);
    spi_xfer(8'hAB, got);
    host_rd(1'b0, rv); chk("R10 disabled ignores", rv, 8'h00);
    host_wr(1'b0, 8'h03);
    spi_xfer(8'hCD, got);
    host_rd(1'b0, rv); chk("R10 master select ignores", rv, 8'h03);
    host_rd(1'b1, rv); chk("R10 buffer untouched", rv, 8'h3F);

    // R4 hardware set vs software clear in the same cycle
    host_wr(1'b0, 8'h01);
    spi_begin();
    spi_bits(8'h69, 8, 1'b1, got);
    spi_end();
    exp_q.push_back(8'h69);
    host_rd(1'b0, rv); chk("R4 hw set wins", rv, 8'h41);
    pop_check("R4 rx byte");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule